// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small set of hardware ownership flags that two independent requesters, called the left and the right port, use to reserve shared resources. Each port picks a flag by the low address bits and writes bit 0 of its data word. A zero asks for the flag and a one gives it back. A port learns whether it holds a flag only by reading it. The holder reads zero and the other side reads one.

A request that arrives while the other side holds the flag is remembered. It turns into ownership in the same cycle the holder lets go. If both ports ask for a free flag in the same cycle, the left port wins and the right port's request waits. A read puts the flag value on every data bit. The value is frozen when the read access starts, so writes made meanwhile by the other port cannot change what the reader sees.

Semaphore accesses use their own select. They count only while the ordinary memory enable of that port is inactive.

Top module: `sem_bank`

## Requirements
- R1: After reset, every semaphore is free with no pending request, so both ports read all ones at every index.
- R2: Requesting a free semaphore (bit 0 of the write data equal to 0) makes the requester the owner. The requester then reads 0 at that index and the other port reads 1.
- R3: The semaphore index is address bits [2:0]. Higher address bits are ignored, and every write data bit other than bit 0 is ignored.
- R4: Only the owner can change an owned semaphore. A release (bit 0 equal to 1) by the owner, with nothing pending, leaves both ports reading 1. A release by the non-owner leaves the ownership unchanged.
- R5: A request from the non-owner is remembered. It makes that port the owner on the same clock edge at which the holder releases.
- R6: When both ports request the same free semaphore in the same cycle, the left port becomes the owner. The right request stays pending and is granted when the left port releases.
- R7: A port that writes 1 while its own request is still pending cancels that request. The current owner is unaffected, and a later release by the owner leaves the semaphore free.
- R8: A write or read counts only when the port's select is high, its memory enable is low, and, for a read, its write strobe is low. Any other combination changes no semaphore and returns no read data.
- R9: A read returns the semaphore bit on all data bits, starting the cycle after the read begins. When no read is active, the read data is all zeros.
- R10: The read value is taken at the first cycle of a read access and held unchanged for as long as the access continues, even if the other port changes the semaphore.
- R11: The eight semaphores are independent. An operation on one index does not change any other index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| l_sel | input | 1 | Left semaphore select |
| l_mem_en | input | 1 | Left ordinary memory enable; blocks semaphore access while high |
| l_wr | input | 1 | Left write strobe |
| l_rd | input | 1 | Left read strobe |
| l_addr | input | ADDR_W (13) | Left address; bits [2:0] pick the semaphore |
| l_wdata | input | DATA_W (16) | Left write data; only bit 0 is used |
| l_rdata | output | DATA_W (16) | Left read data; captured semaphore bit on all lanes |
| r_sel | input | 1 | Right semaphore select |
| r_mem_en | input | 1 | Right ordinary memory enable |
| r_wr | input | 1 | Right write strobe |
| r_rd | input | 1 | Right read strobe |
| r_addr | input | ADDR_W (13) | Right address |
| r_wdata | input | DATA_W (16) | Right write data |
| r_rdata | output | DATA_W (16) | Right read data |

## Verification
A corrupted owner field shows up at the next read of that index. Both ports could read zero together, or a holder could read one, and this is visible one cycle after the read begins. A pending latch that is lost or left set stays hidden until the holder releases. It then shows up one cycle after the release, as a flag that stays free or a flag wrongly handed over. For that reason the sequences read both ports immediately after each release. A capture register that follows live state instead of holding shows only during a long read that overlaps a write from the other port, so one such overlap is driven on purpose.

// File: rtl/sem_pkg.sv
// Shared types for the two-port semaphore bank.
// Assumes: exactly two requesting sides, left and right.
package sem_pkg;
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;
endpackage

// File: rtl/sem_port_dec.sv
// Per-port access qualifier and index decoder.
// Turns one port's strobes into one-hot request and release vectors and a
// read-access flag. Assumes the memory enable, when high, takes the cycle
// away from the semaphore logic.
module sem_port_dec #(
    parameter int NUM_SEM = 8,
    parameter int ADDR_W  = 13,
    parameter int DATA_W  = 16,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic               sel,
    input  logic               mem_en,
    input  logic               wr,
    input  logic               rd,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [NUM_SEM-1:0] req_vec,
    output logic [NUM_SEM-1:0] rel_vec,
    output logic               rd_acc,
    output logic [IDX_W-1:0]   idx
);
    logic acc;
    logic wr_acc;
    logic unused_bits;

    // Qualify the access and pick the index from the low address bits.
    always_comb begin
        acc    = sel && !mem_en;
        wr_acc = acc && wr;
        rd_acc = acc && rd && !wr;
        idx    = addr[IDX_W-1:0];
    end

    // Upper address bits and upper data bits carry no meaning here.
    assign unused_bits = ^{addr[ADDR_W-1:IDX_W], wdata[DATA_W-1:1]};

    // One-hot decode of request (bit0=0) and release (bit0=1) per semaphore.
    for (genvar i = 0; i < NUM_SEM; i++) begin : g_dec
        always_comb begin
            req_vec[i] = wr_acc && (idx == IDX_W'(i)) && !wdata[0];
            rel_vec[i] = wr_acc && (idx == IDX_W'(i)) &&  wdata[0];
        end
    end
endmodule

// File: rtl/sem_cell.sv
// One semaphore: owner field plus one pending-request latch per side.
// Each side's "want" is ownership, a pending request or a new request,
// minus its own release. The holder keeps ownership while it still wants
// it; otherwise the left side wins, then the right. Views are owner-relative:
// 0 means "this side holds it".
module sem_cell
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_l,
    input  logic rel_l,
    input  logic req_r,
    input  logic rel_r,
    output logic view_l,
    output logic view_r
);
    owner_e owner_q, owner_d;
    logic   pend_l_q, pend_r_q;
    logic   pend_l_d, pend_r_d;
    logic   want_l, want_r;

    // Work out the next owner and which requests stay pending.
    always_comb begin
        want_l = ((owner_q == OWN_LEFT)  || pend_l_q || req_l) && !rel_l;
        want_r = ((owner_q == OWN_RIGHT) || pend_r_q || req_r) && !rel_r;
        if (owner_q == OWN_LEFT && want_l)        owner_d = OWN_LEFT;
        else if (owner_q == OWN_RIGHT && want_r)  owner_d = OWN_RIGHT;
        else if (want_l)                          owner_d = OWN_LEFT;
        else if (want_r)                          owner_d = OWN_RIGHT;
        else                                      owner_d = OWN_NONE;
        pend_l_d = want_l && (owner_d != OWN_LEFT);
        pend_r_d = want_r && (owner_d != OWN_RIGHT);
    end

    // State register: free with nothing pending after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q  <= OWN_NONE;
            pend_l_q <= 1'b0;
            pend_r_q <= 1'b0;
        end else begin
            owner_q  <= owner_d;
            pend_l_q <= pend_l_d;
            pend_r_q <= pend_r_d;
        end
    end

    // Owner-relative read views.
    assign view_l = (owner_q != OWN_LEFT);
    assign view_r = (owner_q != OWN_RIGHT);
endmodule

// File: rtl/sem_rd_hold.sv
// Read capture for one port.
// Samples the addressed view on the first cycle of a read access and holds it
// while the access lasts. Output is zero when no read is active.
module sem_rd_hold #(
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 16,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_acc,
    input  logic [IDX_W-1:0]   idx,
    input  logic [NUM_SEM-1:0] view,
    output logic [DATA_W-1:0]  rdata
);
    logic act_q;
    logic bit_q;

    // Capture at read start, hold while the access continues.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            bit_q <= 1'b0;
        end else begin
            act_q <= rd_acc;
            if (rd_acc && !act_q) bit_q <= view[idx];
        end
    end

    // Replicate the held bit on every lane during a read.
    assign rdata = act_q ? {DATA_W{bit_q}} : '0;
endmodule

// File: rtl/sem_bank.sv
// Two-port semaphore bank top.
// Decodes each port, holds NUM_SEM independent semaphore cells and returns
// owner-relative reads through per-port capture registers.
// Assumes both ports share one clock; same-cycle contention favours the left.
module sem_bank #(
    parameter int NUM_SEM = 8,
    parameter int ADDR_W  = 13,
    parameter int DATA_W  = 16,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sel,
    input  logic              l_mem_en,
    input  logic              l_wr,
    input  logic              l_rd,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sel,
    input  logic              r_mem_en,
    input  logic              r_wr,
    input  logic              r_rd,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);
    logic [NUM_SEM-1:0] req_l, rel_l, req_r, rel_r;
    logic [NUM_SEM-1:0] view_l, view_r;
    logic               rd_acc_l, rd_acc_r;
    logic [IDX_W-1:0]   idx_l, idx_r;

    sem_port_dec #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_l (
        .sel(l_sel), .mem_en(l_mem_en), .wr(l_wr), .rd(l_rd),
        .addr(l_addr), .wdata(l_wdata),
        .req_vec(req_l), .rel_vec(rel_l), .rd_acc(rd_acc_l), .idx(idx_l)
    );

    sem_port_dec #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_r (
        .sel(r_sel), .mem_en(r_mem_en), .wr(r_wr), .rd(r_rd),
        .addr(r_addr), .wdata(r_wdata),
        .req_vec(req_r), .rel_vec(rel_r), .rd_acc(rd_acc_r), .idx(idx_r)
    );

    for (genvar i = 0; i < NUM_SEM; i++) begin : g_cell
        sem_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .req_l(req_l[i]), .rel_l(rel_l[i]),
            .req_r(req_r[i]), .rel_r(rel_r[i]),
            .view_l(view_l[i]), .view_r(view_r[i])
        );
    end

    sem_rd_hold #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_hold_l (
        .clk(clk), .rst_n(rst_n), .rd_acc(rd_acc_l), .idx(idx_l),
        .view(view_l), .rdata(l_rdata)
    );

    sem_rd_hold #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_hold_r (
        .clk(clk), .rst_n(rst_n), .rd_acc(rd_acc_r), .idx(idx_r),
        .view(view_r), .rdata(r_rdata)
    );
endmodule

// File: rtl/sem_bank_chk.sv
// Property checker for sem_bank, attached by bind below.
// Watches ports and the owner-relative views driven by the cells.
module sem_bank_chk #(
    parameter int NUM_SEM = 8,
    parameter int ADDR_W  = 13,
    parameter int DATA_W  = 16,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               l_sel,
    input logic               l_mem_en,
    input logic               l_wr,
    input logic               l_rd,
    input logic [ADDR_W-1:0]  l_addr,
    input logic [DATA_W-1:0]  l_wdata,
    input logic [DATA_W-1:0]  l_rdata,
    input logic               r_sel,
    input logic               r_mem_en,
    input logic               r_wr,
    input logic               r_rd,
    input logic [ADDR_W-1:0]  r_addr,
    input logic [DATA_W-1:0]  r_wdata,
    input logic [DATA_W-1:0]  r_rdata,
    input logic [NUM_SEM-1:0] view_l,
    input logic [NUM_SEM-1:0] view_r
);
    logic             lrd, rrd, lreq, rreq;
    logic [IDX_W-1:0] li, ri;

    // Stimulus conditions taken from the ports.
    always_comb begin
        lrd  = l_sel && !l_mem_en && l_rd && !l_wr;
        rrd  = r_sel && !r_mem_en && r_rd && !r_wr;
        lreq = l_sel && !l_mem_en && l_wr && !l_wdata[0];
        rreq = r_sel && !r_mem_en && r_wr && !r_wdata[0];
        li   = l_addr[IDX_W-1:0];
        ri   = r_addr[IDX_W-1:0];
    end

    // R2: a semaphore never appears held by both sides.
    p_single_owner_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (view_l | view_r) == {NUM_SEM{1'b1}});

    // R9: idle read data is zero.
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!lrd && !rrd) |=> (l_rdata == '0) && (r_rdata == '0));

    // R9: read data is all-zeros or all-ones.
    p_lanes_equal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (l_rdata == '0 || l_rdata == '1) && (r_rdata == '0 || r_rdata == '1));

    // R10: left read data is stable while a read continues.
    p_hold_left_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lrd && $past(lrd)) |=> $stable(l_rdata));

    // R10: right read data is stable while a read continues.
    p_hold_right_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rrd && $past(rrd)) |=> $stable(r_rdata));

    // R6: same-cycle requests on a free semaphore go to the left.
    p_left_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lreq && rreq && li == ri && view_l[li] && view_r[li])
        |=> (!view_l[$past(li)] && view_r[$past(li)]));
endmodule

bind sem_bank sem_bank_chk #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .l_mem_en(l_mem_en), .l_wr(l_wr), .l_rd(l_rd),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sel(r_sel), .r_mem_en(r_mem_en), .r_wr(r_wr), .r_rd(r_rd),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
    .view_l(view_l), .view_r(view_r)
);

// File: tb/tb_sem_bank.sv
module tb_sem_bank;
    localparam int ADDR_W = 13;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              l_sel = 0, l_mem_en = 0, l_wr = 0, l_rd = 0;
    logic [ADDR_W-1:0] l_addr = '0;
    logic [DATA_W-1:0] l_wdata = '0;
    logic [DATA_W-1:0] l_rdata;
    logic              r_sel = 0, r_mem_en = 0, r_wr = 0, r_rd = 0;
    logic [ADDR_W-1:0] r_addr = '0;
    logic [DATA_W-1:0] r_wdata = '0;
    logic [DATA_W-1:0] r_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    sem_bank dut (
        .clk(clk), .rst_n(rst_n),
        .l_sel(l_sel), .l_mem_en(l_mem_en), .l_wr(l_wr), .l_rd(l_rd),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_sel(r_sel), .r_mem_en(r_mem_en), .r_wr(r_wr), .r_rd(r_rd),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    always #5ns clk = ~clk;

    typedef struct packed {
        logic              is_rd;
        logic              port;   // 0 left, 1 right
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              exp;
        logic [3:0]        req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 13'h0000, 16'h0000, 1'b1, 4'd1},  // R1 left idle view
        '{1'b1, 1'b1, 13'h0007, 16'h0000, 1'b1, 4'd1},  // R1 right idle view
        '{1'b0, 1'b0, 13'h0005, 16'hFFFE, 1'b0, 4'd2},  // R2 left requests 5
        '{1'b1, 1'b0, 13'h0005, 16'h0000, 1'b0, 4'd2},
        '{1'b1, 1'b1, 13'h0005, 16'h0000, 1'b1, 4'd2},
        '{1'b0, 1'b1, 13'h0005, 16'h0001, 1'b0, 4'd4},  // R4 non-owner release
        '{1'b1, 1'b0, 13'h0005, 16'h0000, 1'b0, 4'd4},
        '{1'b0, 1'b1, 13'h1FF5, 16'h0000, 1'b0, 4'd3},  // R3 upper bits, R5 pend
        '{1'b1, 1'b1, 13'h0005, 16'h0000, 1'b1, 4'd5},
        '{1'b0, 1'b0, 13'h0AD5, 16'h0001, 1'b0, 4'd5},  // R5 release hands over
        '{1'b1, 1'b1, 13'h0005, 16'h0000, 1'b0, 4'd5},
        '{1'b1, 1'b0, 13'h0005, 16'h0000, 1'b1, 4'd5},
        '{1'b0, 1'b1, 13'h0005, 16'hFFFF, 1'b0, 4'd4},  // R4 owner release
        '{1'b1, 1'b0, 13'h0005, 16'h0000, 1'b1, 4'd4},
        '{1'b1, 1'b1, 13'h0005, 16'h0000, 1'b1, 4'd4},
        '{1'b0, 1'b0, 13'h0006, 16'h0000, 1'b0, 4'd7},  // R7 left owns 6
        '{1'b0, 1'b1, 13'h0006, 16'h0000, 1'b0, 4'd7},  // right pends
        '{1'b0, 1'b1, 13'h0006, 16'h0001, 1'b0, 4'd7},  // right cancels
        '{1'b1, 1'b0, 13'h0006, 16'h0000, 1'b0, 4'd7},
        '{1'b0, 1'b0, 13'h0006, 16'h0001, 1'b0, 4'd7},  // left releases
        '{1'b1, 1'b1, 13'h0006, 16'h0000, 1'b1, 4'd7},
        '{1'b1, 1'b0, 13'h0006, 16'h0000, 1'b1, 4'd7},
        '{1'b0, 1'b1, 13'h0001, 16'h0000, 1'b0, 4'd11}, // R11 right owns 1
        '{1'b1, 1'b1, 13'h0001, 16'h0000, 1'b0, 4'd11},
        '{1'b1, 1'b1, 13'h0002, 16'h0000, 1'b1, 4'd11},
        '{1'b1, 1'b1, 13'h0000, 16'h0000, 1'b1, 4'd11},
        '{1'b0, 1'b1, 13'h0001, 16'hFFFE, 1'b0, 4'd3},  // R3 only bit0 counts
        '{1'b1, 1'b0, 13'h0001, 16'h0000, 1'b1, 4'd3},
        '{1'b0, 1'b1, 13'h0001, 16'h8001, 1'b0, 4'd3},  // release, upper data set
        '{1'b1, 1'b0, 13'h0001, 16'h0000, 1'b1, 4'd3}
    };

    task automatic check(input int req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic gap();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_wr(input logic port, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] d);
        if (!port) begin l_sel = 1; l_wr = 1; l_addr = a; l_wdata = d; end
        else       begin r_sel = 1; r_wr = 1; r_addr = a; r_wdata = d; end
        gap();
        l_sel = 0; l_wr = 0; r_sel = 0; r_wr = 0;
        gap();
    endtask

    task automatic do_rd(input logic port, input logic [ADDR_W-1:0] a,
                         input logic e, input int req);
        if (!port) begin l_sel = 1; l_rd = 1; l_addr = a; end
        else       begin r_sel = 1; r_rd = 1; r_addr = a; end
        gap();
        check(req, port ? r_rdata : l_rdata, {DATA_W{e}});
        l_sel = 0; l_rd = 0; r_sel = 0; r_rd = 0;
        gap();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #200us;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        gap();
        check(1, l_rdata, '0);  // R1 reset idle output
        check(9, r_rdata, '0);  // R9 idle zero

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_rd) do_rd(VECS[i].port, VECS[i].addr, VECS[i].exp, int'(VECS[i].req));
            else               do_wr(VECS[i].port, VECS[i].addr, VECS[i].wdata);
        end

        // R6: same-cycle requests on free index 3.
        l_sel = 1; l_wr = 1; l_addr = 3; l_wdata = 0;
        r_sel = 1; r_wr = 1; r_addr = 3; r_wdata = 0;
        gap();
        l_sel = 0; l_wr = 0; r_sel = 0; r_wr = 0;
        gap();
        do_rd(0, 3, 1'b0, 6);
        do_rd(1, 3, 1'b1, 6);
        do_wr(0, 3, 16'h0001);
        do_rd(1, 3, 1'b0, 6);
        do_rd(0, 3, 1'b1, 6);
        do_wr(1, 3, 16'h0001);

        // R8: write with memory enable high, and write without select.
        l_sel = 1; l_mem_en = 1; l_wr = 1; l_addr = 4; l_wdata = 0;
        gap();
        l_sel = 0; l_mem_en = 0; l_wr = 0;
        gap();
        l_wr = 1; l_addr = 4; l_wdata = 0;
        gap();
        l_wr = 0;
        gap();
        do_rd(0, 4, 1'b1, 8);
        do_rd(1, 4, 1'b1, 8);
        // R8: read with memory enable high returns nothing.
        do_wr(0, 4, 16'h0000);
        l_sel = 1; l_mem_en = 1; l_rd = 1; l_addr = 4;
        gap();
        check(8, l_rdata, '0);
        l_sel = 0; l_mem_en = 0; l_rd = 0;
        gap();
        do_rd(0, 4, 1'b0, 9);  // R9 all lanes zero for holder
        do_wr(0, 4, 16'h0001);

        // R10: held read while the other port hands ownership over.
        do_wr(1, 2, 16'h0000);
        do_wr(0, 2, 16'h0000);
        l_sel = 1; l_rd = 1; l_addr = 2;
        gap();
        check(10, l_rdata, 16'hFFFF);
        r_sel = 1; r_wr = 1; r_addr = 2; r_wdata = 16'h0001;
        gap();
        r_sel = 0; r_wr = 0;
        check(10, l_rdata, 16'hFFFF);
        gap();
        check(10, l_rdata, 16'hFFFF);
        l_sel = 0; l_rd = 0;
        gap();
        check(9, l_rdata, '0);
        do_rd(0, 2, 1'b0, 5);
        do_rd(1, 2, 1'b1, 10);

        // R1: reset with semaphores held and pending.
        do_wr(0, 0, 16'h0000);
        do_wr(1, 7, 16'h0000);
        do_wr(1, 0, 16'h0000);
        rst_n = 0;
        gap();
        gap();
        rst_n = 1;
        gap();
        for (int i = 0; i < 8; i++) begin
            do_rd(0, ADDR_W'(i), 1'b1, 1);
            do_rd(1, ADDR_W'(i), 1'b1, 1);
        end
        // R1: no stale pending request survives reset.
        do_wr(0, 0, 16'h0000);
        do_wr(0, 0, 16'h0001);
        do_rd(1, 0, 1'b1, 1);

        finish_run();
    end
endmodule